// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This unit compares two IEEE-754 operands, either single precision (32 bits) or double precision (64 bits), and reduces the comparison to one true/false compare flag. A 3-bit condition code picks one of eight predicates. The predicates combine four relations: less, equal, greater and unordered. Ordered forms are false when either operand is a NaN. Unordered forms are true in that case.

Each operand is first classified into sign, magnitude, NaN, signalling NaN and zero. The two classifications are reduced to exactly one relation, and the selected predicate is applied to that relation. The flag, a pulse that reports a signalling-NaN exception, and a 4-bit image of status-register bits 31:28 are registered. They appear one cycle after the valid strobe, together with an update strobe. Arithmetic is not part of this unit.

Top module: `fcmp_pred_unit`

## Requirements
- R1: `stat_we` is high in exactly the cycles that follow a cycle with `in_valid` high. The flag, the exception pulse and the status image for that operation appear in the same cycle as the strobe.
- R2: Code 0 always gives a flag of 0. Code 1 gives 1 only when the operands are unordered, meaning either operand is a NaN.
- R3: Code 2 gives 1 when the operands are equal. Code 3 gives 1 when they are equal or unordered.
- R4: Code 4 gives 1 only when A < B and both operands are ordered. Code 5 gives 1 when A < B or when the operands are unordered.
- R5: Code 6 gives 1 when A <= B and both operands are ordered. Code 7 gives 1 in every case except A > B.
- R6: Only `cond[2:0]` selects the predicate. Bits `cond[7:3]` have no effect on any output.
- R7: +0 and -0 compare equal in both precisions.
- R8: A NaN has an exponent of all ones and a non-zero fraction. It is signalling when the fraction MSB is 0 (bit 22 in single precision, bit 51 in double precision). `inval_flag` pulses with the result only when either operand is a signalling NaN. Quiet NaNs never raise it.
- R9: When `dbl_sel` is 0, the unit uses only bits 31:0 of each operand, and bits 63:32 have no effect. When `dbl_sel` is 1, the unit uses all 64 bits. The predicate meaning is the same in both precisions.
- R10: `stat_hi` holds status bits 31:28, with the compare flag at bit 29 (`stat_hi[1]`) and bits 31, 30 and 28 at 0.
- R11: After reset, all outputs are 0. Without a valid strobe, `cmp_flag` and `stat_hi` keep their last values, and `inval_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision in the low 32 bits |
| cond | input | 8 | Predicate code; only bits 2:0 are used |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| stat_we | output | 1 | Status update strobe, one cycle after `in_valid` |
| cmp_flag | output | 1 | Registered predicate result |
| inval_flag | output | 1 | Signalling-NaN exception pulse |
| stat_hi | output | 4 | Status bits 31:28 with the flag at bit 29 |

## Verification
In a single cycle the unit can both raise the invalid exception and deliver a true predicate result. This happens when a signalling NaN meets an unordered predicate such as code 1, 3, 5 or 7. The bench provokes it by pairing signalling NaNs with every code, in both precisions. The bench's reference model predicts the flag and the exception independently, and both must appear in the strobe cycle. Back-to-back strobes with changing codes are mixed with idle cycles, so that holding the flag and clearing the pulse are also judged against the model.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int DATA_W    = 64;
    localparam int MAG_W     = DATA_W - 1;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int CODE_W    = 3;
    localparam int STAT_W    = 4;
    localparam int FLAG_POS  = 1;   // bit 29 inside status bits 31:28

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             snan;
        logic             zero;
    } opclass_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } rel_t;

    typedef struct packed {
        logic we;
        logic flag;
        logic inval;
    } state_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic              dbl_sel,
    input  logic [DATA_W-1:0] op,
    output opclass_t          cls
);
    logic [SP_EXP_W-1:0]  sp_exp;
    logic [SP_FRAC_W-1:0] sp_frac;
    logic [DP_EXP_W-1:0]  dp_exp;
    logic [DP_FRAC_W-1:0] dp_frac;
    logic                 exp_ones;
    logic                 frac_nz;
    logic                 quiet;

    assign sp_exp  = op[SP_W-2 -: SP_EXP_W];
    assign sp_frac = op[SP_FRAC_W-1:0];
    assign dp_exp  = op[DATA_W-2 -: DP_EXP_W];
    assign dp_frac = op[DP_FRAC_W-1:0];

    always_comb begin
        cls = '0;
        if (dbl_sel) begin
            cls.sign = op[DATA_W-1];
            cls.mag  = op[MAG_W-1:0];
            exp_ones = &dp_exp;
            frac_nz  = |dp_frac;
            quiet    = dp_frac[DP_FRAC_W-1];
        end else begin
            cls.sign = op[SP_W-1];
            cls.mag  = {{(DATA_W-SP_W){1'b0}}, op[SP_W-2:0]};
            exp_ones = &sp_exp;
            frac_nz  = |sp_frac;
            quiet    = sp_frac[SP_FRAC_W-1];
        end
        cls.nan  = exp_ones & frac_nz;
        cls.snan = cls.nan & ~quiet;
        cls.zero = (cls.mag == '0);
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opclass_t a,
    input  opclass_t b,
    output rel_t     rel
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt = (a.mag < b.mag);
    assign mag_eq = (a.mag == b.mag);

    always_comb begin
        rel = '0;
        if (a.nan || b.nan) begin
            rel.un = 1'b1;
        end else if ((a.zero && b.zero) || ((a.sign == b.sign) && mag_eq)) begin
            rel.eq = 1'b1;
        end else if (a.sign != b.sign) begin
            rel.lt = a.sign;
            rel.gt = b.sign;
        end else if (a.sign) begin
            rel.lt = ~mag_lt;
            rel.gt = mag_lt;
        end else begin
            rel.lt = mag_lt;
            rel.gt = ~mag_lt;
        end
    end
endmodule

// File: rtl/fcmp_pred_sel.sv
module fcmp_pred_sel
    import fcmp_pkg::*;
(
    input  rel_t              rel,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    // code bit 0 admits unordered, bit 1 admits equal, bit 2 admits less
    assign hit = (code[0] & rel.un) | (code[1] & rel.eq) | (code[2] & rel.lt);
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
    import fcmp_pkg::*;
#(
    parameter int COND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              dbl_sel,
    input  logic [COND_W-1:0] cond,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              stat_we,
    output logic              cmp_flag,
    output logic              inval_flag,
    output logic [STAT_W-1:0] stat_hi
);
    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][DATA_W-1:0] ops;
    opclass_t                       cls [NUM_OPS];
    rel_t                           rel;
    logic                           hit;
    logic                           unused_cond_hi;
    state_t                         st_d;
    state_t                         st_q;

    assign ops            = {op_b, op_a};
    assign unused_cond_hi = ^cond[COND_W-1:CODE_W];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fcmp_classify u_cls (
            .dbl_sel (dbl_sel),
            .op      (ops[g]),
            .cls     (cls[g])
        );
    end

    fcmp_relate u_rel (
        .a   (cls[0]),
        .b   (cls[1]),
        .rel (rel)
    );

    fcmp_pred_sel u_sel (
        .rel  (rel),
        .code (cond[CODE_W-1:0]),
        .hit  (hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = in_valid;
        st_d.inval = in_valid & (cls[0].snan | cls[1].snan);
        if (in_valid) begin
            st_d.flag = hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_hi           = '0;
        stat_hi[FLAG_POS] = st_q.flag;
    end

    assign stat_we    = st_q.we;
    assign cmp_flag   = st_q.flag;
    assign inval_flag = st_q.inval;
endmodule

// File: rtl/fcmp_pred_unit_chk.sv
module fcmp_pred_unit_chk #(
    parameter int COND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [COND_W-1:0] cond,
    input logic              stat_we,
    input logic              cmp_flag,
    input logic              inval_flag
);
    p_we_follows_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> stat_we);

    p_we_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !stat_we);

    p_false_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond[2:0] == 3'd0) |=> !cmp_flag);

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cmp_flag));

    p_inval_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |-> !inval_flag);
endmodule

bind fcmp_pred_unit fcmp_pred_unit_chk #(.COND_W(COND_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .cond       (cond),
    .stat_we    (stat_we),
    .cmp_flag   (cmp_flag),
    .inval_flag (inval_flag)
);

// File: tb/tb_fcmp_pred_unit.sv
module tb_fcmp_pred_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dbl_sel = 1'b0;
    logic [7:0]  cond = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        stat_we;
    logic        cmp_flag;
    logic        inval_flag;
    logic [3:0]  stat_hi;

    int errors = 0;
    int checks = 0;

    // reference state
    bit m_we = 0;
    bit m_flag = 0;
    bit m_inv = 0;

    always #5 clk = ~clk;

    fcmp_pred_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
        .cond(cond), .op_a(op_a), .op_b(op_b), .stat_we(stat_we),
        .cmp_flag(cmp_flag), .inval_flag(inval_flag), .stat_hi(stat_hi)
    );

    localparam logic [63:0] S_ONE  = 64'h3F80_0000, S_TWO  = 64'h4000_0000;
    localparam logic [63:0] S_MONE = 64'hBF80_0000, S_MTWO = 64'hC000_0000;
    localparam logic [63:0] S_QNAN = 64'h7FC0_0000, S_SNAN = 64'h7F80_0001;
    localparam logic [63:0] S_PINF = 64'h7F80_0000, S_MZER = 64'h8000_0000;
    localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_MZER = 64'h8000_0000_0000_0000;

    function automatic bit f_nan(bit dbl, logic [63:0] x);
        if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit f_snan(bit dbl, logic [63:0] x);
        return f_nan(dbl, x) && !(dbl ? x[51] : x[22]);
    endfunction

    // signed ordering key: -0 and +0 map to the same value
    function automatic longint f_key(bit dbl, logic [63:0] x);
        longint m;
        bit s;
        m = dbl ? longint'({1'b0, x[62:0]}) : longint'({33'b0, x[30:0]});
        s = dbl ? x[63] : x[31];
        return s ? -m : m;
    endfunction

    function automatic bit f_pred(bit dbl, logic [2:0] c, logic [63:0] a, logic [63:0] b);
        bit un, lt, eq, gt;
        un = f_nan(dbl, a) || f_nan(dbl, b);
        lt = !un && (f_key(dbl, a) <  f_key(dbl, b));
        eq = !un && (f_key(dbl, a) == f_key(dbl, b));
        gt = !un && (f_key(dbl, a) >  f_key(dbl, b));
        case (c)
            3'd0: return 1'b0;
            3'd1: return un;
            3'd2: return eq;
            3'd3: return eq || un;
            3'd4: return lt;
            3'd5: return lt || un;
            3'd6: return lt || eq;
            default: return !gt;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] c);
        case (c)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4, 3'd5: return "R4";
            default:    return "R5";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " R1 we"}, 64'(stat_we), 64'(m_we));
        chk({tag, " flag"}, 64'(cmp_flag), 64'(m_flag));
        chk({tag, " R8 inval"}, 64'(inval_flag), 64'(m_inv));
        chk({tag, " R10 stat_hi"}, 64'(stat_hi), {60'b0, 2'b00, m_flag, 1'b0});
    endtask

    // called at a negedge; drives, updates the model, compares at the next negedge
    task automatic step(bit v, bit dbl, logic [7:0] c, logic [63:0] a, logic [63:0] b, string tag);
        in_valid = v; dbl_sel = dbl; cond = c; op_a = a; op_b = b;
        m_we  = v;
        m_inv = v && (f_snan(dbl, a) || f_snan(dbl, b));
        if (v) m_flag = f_pred(dbl, c[2:0], a, b);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] sa [4];
        logic [63:0] sb [4];
        logic [63:0] da [4];
        logic [63:0] db [4];
        sa = '{S_ONE, S_TWO, S_ONE, S_QNAN};
        sb = '{S_TWO, S_ONE, S_ONE, S_ONE};
        da = '{D_ONE, D_TWO, D_ONE, D_QNAN};
        db = '{D_TWO, D_ONE, D_ONE, D_ONE};

        repeat (3) @(negedge clk);
        compare_all("R11 reset");
        rst_n = 1'b1;

        // predicate table for less, greater, equal, unordered in both precisions
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 4; p++) begin
                step(1, 0, 8'(c), sa[p], sb[p], {tag_of(3'(c)), " R9 single"});
                step(1, 1, 8'(c), da[p], db[p], {tag_of(3'(c)), " R9 double"});
            end
        end

        // R7 signed zeros
        for (int c = 0; c < 8; c++) begin
            step(1, 0, 8'(c), S_MZER, 64'h0, "R7 single zero");
            step(1, 1, 8'(c), 64'h0, D_MZER, "R7 double zero");
        end

        // R8 signalling versus quiet NaN, with predicate results in the same cycle
        for (int c = 0; c < 8; c++) begin
            step(1, 0, 8'(c), S_SNAN, S_ONE, "R8 single snan");
            step(1, 1, 8'(c), D_ONE, D_SNAN, "R8 double snan");
            step(1, 0, 8'(c), S_ONE, S_QNAN, "R8 single qnan");
            step(1, 1, 8'(c), D_QNAN, D_QNAN, "R8 double qnan");
        end

        // negative and infinite ordering
        step(1, 0, 8'd4, S_MTWO, S_MONE, "R4 negative lt");
        step(1, 0, 8'd4, S_MONE, S_MTWO, "R4 negative gt");
        step(1, 0, 8'd6, S_MONE, S_ONE, "R5 mixed sign");
        step(1, 0, 8'd7, S_PINF, S_ONE, "R5 inf gt");
        step(1, 1, 8'd4, D_MONE, D_ONE, "R4 double neg");

        // R6 upper condition bits ignored
        for (int c = 0; c < 8; c++) begin
            step(1, 0, 8'(c) | 8'hF8, S_ONE, S_TWO, "R6 upper cond lt");
            step(1, 1, 8'(c) | 8'hA8, D_QNAN, D_ONE, "R6 upper cond un");
        end

        // R9 upper half ignored in single precision
        step(1, 0, 8'd2, {32'hDEAD_BEEF, 32'h3F80_0000}, {32'h0123_4567, 32'h3F80_0000}, "R9 upper ignored eq");
        step(1, 0, 8'd4, {32'hFFFF_FFFF, 32'h3F80_0000}, {32'h0, 32'h4000_0000}, "R9 upper ignored lt");
        step(1, 0, 8'd1, {32'h7FF0_0000, 32'h3F80_0000}, {32'h7FF0_0001, 32'h4000_0000}, "R9 upper no nan");

        // R11 hold and pulse clearing across idle cycles
        step(1, 0, 8'd7, S_ONE, S_ONE, "R11 set");
        step(0, 0, 8'd0, S_SNAN, S_TWO, "R11 idle hold");
        step(0, 1, 8'd0, D_SNAN, D_ONE, "R11 idle hold2");
        step(1, 1, 8'd1, D_SNAN, D_ONE, "R11 pulse");
        step(0, 0, 8'd0, 64'h0, 64'h0, "R11 pulse clears");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            bit dbl;
            int sel;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            dbl = $urandom_range(0, 1) == 1;
            sel = $urandom_range(0, 7);
            if (sel == 0) b = a;
            if (sel == 1) begin b = a; b[dbl ? 63 : 31] = ~a[dbl ? 63 : 31]; end
            if (sel == 2) begin
                if (dbl) a[62:52] = '1; else a[30:23] = '1;
            end
            if (sel == 3) begin
                if (dbl) b[62:0] = '0; else b[30:0] = '0;
                if (dbl) a[62:0] = '0; else a[30:0] = '0;
            end
            step($urandom_range(0, 3) != 0, dbl, 8'($urandom()), a, b, "random R1");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule